// File: doc/BRIEF.md
# Toggle-Bit NOR Flash Command Sequencer

This block drives a 16-bit parallel NOR flash that takes the two-write unlock command set and reports completion through a toggling status bit. A client hands it one request at a time: sector erase or buffered program, a word address, and for a program a word count. The block then issues every write of the command sequence on its own. During a program it pulls the data words from the client one per cycle. It watches the device's status reads until the work ends and reports the outcome on a one-cycle completion pulse with a two-bit status code.

The flash side is a plain single-cycle access port. In every cycle with `bus_en` high exactly one access takes place. With `bus_we` high it is a write of `bus_wdata` to `bus_addr`. With `bus_we` low it is a read of `bus_addr`, and `bus_rdata` is sampled at the end of that same cycle. An erase is not finished until the device is no longer toggling. When the device reports an error or never settles, the block writes the abort-reset sequence, which returns the part to array mode before the next request. The same sequence is written once after every reset.

Status codes: 0 = success, 1 = device error, 2 = timeout, 3 = request rejected. Request kind: `op_program` = 0 selects erase, 1 selects program.

Top module: `nfc_seq_ctrl`

## Requirements
- R1: During reset the block makes no access, no pulse and does not accept work. From the second cycle after reset is released it writes 0xAA@0x555, 0x55@0x2AA, 0xF0@0x555 on consecutive cycles. It raises no `done` for this sequence and then becomes ready.
- R2: An erase request (`op_program`=0) writes on consecutive cycles, starting the cycle after acceptance: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30@sector address.
- R3: After the erase command the block reads the sector address once per cycle. It starts toggle polling only in the cycle after a read with bit 3 (0x08) set.
- R4: A poll is three back-to-back reads. The device counts as busy only if bit 6 differs between reads one and two and also between reads two and three. When it is not busy, `done` is high for exactly one cycle, the cycle after the third read, with status 0.
- R5: When a poll finds the device busy and the first read shares a bit with the stop mask, the abort reset (0xAA@0x555, 0x55@0x2AA, 0xF0@0x555) starts in the next cycle. `done` with status 1 follows the cycle after the 0xF0 write.
- R6: The stop mask is 0x20 for erase and 0x22 for program. A busy poll whose first read has only bit 1 set keeps an erase polling and fails a program.
- R7: A program request (`op_program`=1, count N) writes 0xAA@0x555, 0x55@0x2AA, 0x25@address, N-1@address. It then writes the N client words at address, address+1, ... with `data_take` high in each of those cycles, then 0x29@address, and then polls reads at the address.
- R8: A request with count 0 or above BUF_WORDS is rejected with no access. `done` is high in the next cycle with status 3. BUF_WORDS itself is accepted.
- R9: A timeout has two causes: the POLL_LIMIT-th consecutive busy poll without a stop-mask hit, or the POLL_LIMIT-th read without bit 3 while waiting after erase. Either one starts the abort reset in the next cycle and ends with `done` and status 2.
- R10: `op_ready` is high only when the block is idle. A request held on `op_valid` while a job runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Request present; taken when `op_ready` is high |
| op_ready | output | 1 | Block idle and able to take a request |
| op_program | input | 1 | 0 = sector erase, 1 = buffered program |
| op_addr | input | AW | Word address of the sector or program start |
| op_count | input | CW | Program word count, 1..BUF_WORDS |
| wr_data | input | DW | Current program data word from the client |
| data_take | output | 1 | `wr_data` is consumed this cycle |
| bus_en | output | 1 | Flash access this cycle |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Flash word address |
| bus_wdata | output | DW | Flash write data |
| bus_rdata | input | DW | Flash read data, sampled at the end of a read cycle |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Outcome code, valid with `done` |

## Verification
Each result has a fixed delay. The first command write comes one cycle after acceptance. A rejection pulses `done` one cycle after acceptance. A success pulses `done` one cycle after the third poll read. Each failure pulses `done` one cycle after the 0xF0 abort write. Read timing depends on the status values the flash returns, so the bench works out the full cycle list for each scenario from the requirements before it issues the request. That list covers every write, every read with the value it returns, and the completion cycle. The bench checks one entry at each falling clock edge, so any extra, missing or late access, and any pulse in the wrong cycle, is a miscompare.

// File: rtl/nfc_pkg.sv
// Shared types and command constants for the toggle-bit NOR sequencer.
// Assumes a 16-bit data path and word addressing on the flash side.
package nfc_pkg;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_DEVFAIL = 2'd1,
        ST_TIMEOUT = 2'd2,
        ST_REJECT  = 2'd3
    } nfc_status_e;

    typedef enum logic [1:0] {
        FL_ABORT = 2'd0,
        FL_ERASE = 2'd1,
        FL_PROG  = 2'd2
    } nfc_flow_e;

    typedef enum logic [3:0] {
        S_BOOT  = 4'd0,
        S_IDLE  = 4'd1,
        S_SEQ   = 4'd2,
        S_DATA  = 4'd3,
        S_CONF  = 4'd4,
        S_WAIT3 = 4'd5,
        S_POLL1 = 4'd6,
        S_POLL2 = 4'd7,
        S_POLL3 = 4'd8
    } nfc_state_e;

    localparam logic [11:0] KEY_ADDR_A     = 12'h555;
    localparam logic [11:0] KEY_ADDR_B     = 12'h2AA;
    localparam logic [7:0]  KEY_DATA_A     = 8'hAA;
    localparam logic [7:0]  KEY_DATA_B     = 8'h55;
    localparam logic [7:0]  CMD_ERASE_ARM  = 8'h80;
    localparam logic [7:0]  CMD_ERASE_GO   = 8'h30;
    localparam logic [7:0]  CMD_BUF_LOAD   = 8'h25;
    localparam logic [7:0]  CMD_BUF_COMMIT = 8'h29;
    localparam logic [7:0]  CMD_ARRAY_RST  = 8'hF0;
    localparam logic [7:0]  MASK_ERASE     = 8'h20;
    localparam logic [7:0]  MASK_PROG      = 8'h22;
    localparam int          TOGGLE_BIT     = 6;
    localparam int          ERASE_ACK_BIT  = 3;

endpackage

// File: rtl/nfc_cmd_rom.sv
// Command step table: returns the address and data of a fixed write
// for a flow and a step index, and flags the final step of that flow.
// Assumes idx is held in range by the caller (it stops on 'last').
module nfc_cmd_rom
    import nfc_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  nfc_flow_e         flow,
    input  logic [2:0]        idx,
    input  logic [AW-1:0]     sect_addr,
    input  logic [DW-1:0]     count_m1,
    output logic [AW-1:0]     cyc_addr,
    output logic [DW-1:0]     cyc_data,
    output logic              last
);

    localparam logic [AW-1:0] A_KEY1 = AW'(KEY_ADDR_A);
    localparam logic [AW-1:0] A_KEY2 = AW'(KEY_ADDR_B);

    // Decode one step; steps 0/1 of every flow and 3/4 of erase are key writes
    always_comb begin
        cyc_addr = A_KEY1;
        cyc_data = DW'(KEY_DATA_A);
        last     = 1'b0;
        unique case (flow)
            FL_ABORT: begin
                unique case (idx)
                    3'd0:    begin cyc_addr = A_KEY1; cyc_data = DW'(KEY_DATA_A); end
                    3'd1:    begin cyc_addr = A_KEY2; cyc_data = DW'(KEY_DATA_B); end
                    default: begin cyc_addr = A_KEY1; cyc_data = DW'(CMD_ARRAY_RST); last = 1'b1; end
                endcase
            end
            FL_ERASE: begin
                unique case (idx)
                    3'd0, 3'd3: begin cyc_addr = A_KEY1; cyc_data = DW'(KEY_DATA_A); end
                    3'd1, 3'd4: begin cyc_addr = A_KEY2; cyc_data = DW'(KEY_DATA_B); end
                    3'd2:       begin cyc_addr = A_KEY1; cyc_data = DW'(CMD_ERASE_ARM); end
                    default:    begin cyc_addr = sect_addr; cyc_data = DW'(CMD_ERASE_GO); last = 1'b1; end
                endcase
            end
            default: begin
                unique case (idx)
                    3'd0:    begin cyc_addr = A_KEY1; cyc_data = DW'(KEY_DATA_A); end
                    3'd1:    begin cyc_addr = A_KEY2; cyc_data = DW'(KEY_DATA_B); end
                    3'd2:    begin cyc_addr = sect_addr; cyc_data = DW'(CMD_BUF_LOAD); end
                    default: begin cyc_addr = sect_addr; cyc_data = count_m1; last = 1'b1; end
                endcase
            end
        endcase
    end

endmodule

// File: rtl/nfc_toggle_eval.sv
// Judges one three-read status poll: busy when the toggle bit flips
// on both adjacent pairs; a stop hit when busy and read one meets the mask.
// Assumes the three reads are consecutive reads of the same address.
module nfc_toggle_eval
    import nfc_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] rd_a,
    input  logic [DW-1:0] rd_b,
    input  logic [DW-1:0] rd_c,
    input  logic [DW-1:0] stop_mask,
    output logic          busy,
    output logic          stop_hit
);

    logic [DW-1:0] flip_ab;
    logic [DW-1:0] flip_bc;

    // Per-bit change masks across the two read pairs
    always_comb begin
        flip_ab = rd_a ^ rd_b;
        flip_bc = rd_b ^ rd_c;
    end

    // Busy needs both pairs to change; error needs busy and a mask bit
    always_comb begin
        busy     = flip_ab[TOGGLE_BIT] & flip_bc[TOGGLE_BIT];
        stop_hit = busy & (|(rd_a & stop_mask));
    end

endmodule

// File: rtl/nfc_poll_guard.sv
// Bounded wait counter shared by the erase-ack wait and the toggle poll.
// 'last' is high on the LIMIT-th attempt since the last clear.
// Assumes LIMIT >= 2.
module nfc_poll_guard #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic last
);

    localparam int GW = $clog2(LIMIT + 1);

    logic [GW-1:0] cnt;

    // Attempt counter: clear has priority over step
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (step)   cnt <= cnt + 1'b1;
    end

    // Flag the final permitted attempt
    always_comb last = (cnt == GW'(LIMIT - 1));

endmodule

// File: rtl/nfc_seq_ctrl.sv
// Toggle-bit NOR command sequencer (top). Takes one erase or buffered
// program request, writes the unlock and command cycles, polls for
// completion and writes an abort reset after any failure and once after
// reset. Assumes a single-cycle flash access port and DW >= 8.
module nfc_seq_ctrl
    import nfc_pkg::*;
#(
    parameter  int AW         = 24,
    parameter  int DW         = 16,
    parameter  int BUF_WORDS  = 16,
    parameter  int POLL_LIMIT = 4096,
    localparam int CW         = $clog2(BUF_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    output logic          op_ready,
    input  logic          op_program,
    input  logic [AW-1:0] op_addr,
    input  logic [CW-1:0] op_count,
    input  logic [DW-1:0] wr_data,
    output logic          data_take,
    output logic          bus_en,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic          done,
    output logic [1:0]    status
);

    nfc_state_e    state;
    nfc_flow_e     flow;
    nfc_status_e   pend;
    nfc_status_e   st_q;
    logic [2:0]    idx;
    logic [AW-1:0] base_addr;
    logic [CW-1:0] cnt_m1;
    logic [CW-1:0] widx;
    logic          is_prog;
    logic          init_run;
    logic [DW-1:0] rd1;
    logic [DW-1:0] rd2;

    logic [AW-1:0] rom_addr;
    logic [DW-1:0] rom_data;
    logic          rom_last;
    logic          tog_busy;
    logic          tog_stop;
    logic          g_clr;
    logic          g_step;
    logic          g_last;
    logic [DW-1:0] stop_mask;
    logic          req_ok;
    logic          ack_seen;

    nfc_cmd_rom #(.AW(AW), .DW(DW)) u_rom (
        .flow      (flow),
        .idx       (idx),
        .sect_addr (base_addr),
        .count_m1  (DW'(cnt_m1)),
        .cyc_addr  (rom_addr),
        .cyc_data  (rom_data),
        .last      (rom_last)
    );

    nfc_toggle_eval #(.DW(DW)) u_tog (
        .rd_a      (rd1),
        .rd_b      (rd2),
        .rd_c      (bus_rdata),
        .stop_mask (stop_mask),
        .busy      (tog_busy),
        .stop_hit  (tog_stop)
    );

    nfc_poll_guard #(.LIMIT(POLL_LIMIT)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (g_clr),
        .step  (g_step),
        .last  (g_last)
    );

    // Request screening, stop mask choice and erase-ack detection
    always_comb begin
        req_ok    = (op_count != '0) && (op_count <= CW'(BUF_WORDS));
        stop_mask = is_prog ? DW'(MASK_PROG) : DW'(MASK_ERASE);
        ack_seen  = bus_rdata[ERASE_ACK_BIT];
    end

    // Guard control: restart at each wait phase, count failed attempts
    always_comb begin
        g_clr  = (state == S_SEQ && rom_last && flow == FL_ERASE)
               || (state == S_CONF)
               || (state == S_WAIT3 && ack_seen);
        g_step = (state == S_WAIT3 && !ack_seen)
               || (state == S_POLL3 && tog_busy && !tog_stop);
    end

    // Flash access port and client handshake decoded from the state
    always_comb begin
        bus_en    = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = base_addr;
        bus_wdata = '0;
        data_take = 1'b0;
        unique case (state)
            S_SEQ: begin
                bus_en    = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = rom_addr;
                bus_wdata = rom_data;
            end
            S_DATA: begin
                bus_en    = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = base_addr + AW'(widx);
                bus_wdata = wr_data;
                data_take = 1'b1;
            end
            S_CONF: begin
                bus_en    = 1'b1;
                bus_we    = 1'b1;
                bus_wdata = DW'(CMD_BUF_COMMIT);
            end
            S_WAIT3, S_POLL1, S_POLL2, S_POLL3: begin
                bus_en    = 1'b1;
            end
            default: ;
        endcase
        op_ready = (state == S_IDLE);
        status   = st_q;
    end

    // Main sequencer: step through flows, poll, report and recover
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_BOOT;
            flow      <= FL_ABORT;
            idx       <= '0;
            base_addr <= '0;
            cnt_m1    <= '0;
            widx      <= '0;
            is_prog   <= 1'b0;
            init_run  <= 1'b1;
            rd1       <= '0;
            rd2       <= '0;
            pend      <= ST_OK;
            done      <= 1'b0;
            st_q      <= ST_OK;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_BOOT: begin
                    state <= S_SEQ;
                    flow  <= FL_ABORT;
                    idx   <= '0;
                end
                S_IDLE: begin
                    if (op_valid) begin
                        if (!req_ok) begin
                            done <= 1'b1;
                            st_q <= ST_REJECT;
                        end else begin
                            base_addr <= op_addr;
                            cnt_m1    <= op_count - 1'b1;
                            is_prog   <= op_program;
                            flow      <= op_program ? FL_PROG : FL_ERASE;
                            idx       <= '0;
                            state     <= S_SEQ;
                        end
                    end
                end
                S_SEQ: begin
                    if (!rom_last) begin
                        idx <= idx + 1'b1;
                    end else begin
                        unique case (flow)
                            FL_ABORT: begin
                                state    <= S_IDLE;
                                init_run <= 1'b0;
                                if (!init_run) begin
                                    done <= 1'b1;
                                    st_q <= pend;
                                end
                            end
                            FL_ERASE: state <= S_WAIT3;
                            default: begin
                                state <= S_DATA;
                                widx  <= '0;
                            end
                        endcase
                    end
                end
                S_DATA: begin
                    if (widx == cnt_m1) state <= S_CONF;
                    else                widx  <= widx + 1'b1;
                end
                S_CONF: state <= S_POLL1;
                S_WAIT3: begin
                    if (ack_seen) begin
                        state <= S_POLL1;
                    end else if (g_last) begin
                        state <= S_SEQ;
                        flow  <= FL_ABORT;
                        idx   <= '0;
                        pend  <= ST_TIMEOUT;
                    end
                end
                S_POLL1: begin
                    rd1   <= bus_rdata;
                    state <= S_POLL2;
                end
                S_POLL2: begin
                    rd2   <= bus_rdata;
                    state <= S_POLL3;
                end
                S_POLL3: begin
                    if (!tog_busy) begin
                        done  <= 1'b1;
                        st_q  <= ST_OK;
                        state <= S_IDLE;
                    end else if (tog_stop || g_last) begin
                        state <= S_SEQ;
                        flow  <= FL_ABORT;
                        idx   <= '0;
                        pend  <= tog_stop ? ST_DEVFAIL : ST_TIMEOUT;
                    end else begin
                        state <= S_POLL1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nfc_seq_checker.sv
// Protocol checker for nfc_seq_ctrl, attached with bind below.
// Assumes the bound instance's own parameter values are passed in.
module nfc_seq_checker
    import nfc_pkg::*;
#(
    parameter  int AW        = 24,
    parameter  int DW        = 16,
    parameter  int BUF_WORDS = 16,
    localparam int CW        = $clog2(BUF_WORDS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic          op_ready,
    input logic [CW-1:0] op_count,
    input logic          data_take,
    input logic          bus_en,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic          done,
    input logic [1:0]    status,
    input nfc_state_e    state
);

    // R1: quiet while booting
    a_r1_boot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BOOT) |-> (!bus_en && !done && !op_ready));

    // R3: a read without the ack bit keeps waiting or aborts, never polls
    a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT3 && !bus_rdata[ERASE_ACK_BIT])
        |=> (state == S_WAIT3 || (bus_en && bus_we)));

    // R4: success is reported right after a status read
    a_r4_ok_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == ST_OK) |-> $past(bus_en && !bus_we));

    // R4: completion is a single-cycle pulse
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: error and timeout reports follow the abort-reset write
    a_r5_fail_after_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (status == ST_DEVFAIL || status == ST_TIMEOUT))
        |-> $past(bus_en && bus_we && bus_addr == AW'(KEY_ADDR_A)
                  && bus_wdata == DW'(CMD_ARRAY_RST)));

    // R7: client data is only consumed by a flash write
    a_r7_take_is_write: assert property (@(posedge clk) disable iff (!rst_n)
        data_take |-> (bus_en && bus_we));

    // R8: rejected request gives a pulse with no access
    a_r8_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && (op_count == '0 || op_count > CW'(BUF_WORDS)))
        |=> (done && status == ST_REJECT && !bus_en));

    // R10: ready only while the access port is quiet
    a_r10_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        op_ready |-> (!bus_en && !data_take));

endmodule

bind nfc_seq_ctrl nfc_seq_checker #(
    .AW        (AW),
    .DW        (DW),
    .BUF_WORDS (BUF_WORDS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_ready  (op_ready),
    .op_count  (op_count),
    .data_take (data_take),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .done      (done),
    .status    (status),
    .state     (state)
);

// File: tb/sim_nfc_seq_ctrl.sv
module sim_nfc_seq_ctrl;

    localparam int AW    = 24;
    localparam int DW    = 16;
    localparam int BUFW  = 16;
    localparam int LIMIT = 5;
    localparam int CW    = $clog2(BUFW + 1);

    localparam int K_BOOT = 0, K_IDLE = 1, K_WR = 2, K_RD = 3, K_DONE = 4;

    typedef struct {
        int    kind;
        int    addr;
        int    wdata;
        int    rdata;
        int    take;
        int    st;
        string req;
    } ent_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic          op_ready;
    logic          op_program = 1'b0;
    logic [AW-1:0] op_addr = '0;
    logic [CW-1:0] op_count = '0;
    logic [DW-1:0] wr_data = '0;
    logic          data_take;
    logic          bus_en;
    logic          bus_we;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic          done;
    logic [1:0]    status;

    ent_t q[$];
    bit   armed = 1'b0;
    int   n_vec = 0;
    int   n_bad = 0;
    string cur = "R1";

    always #5 clk = ~clk;

    nfc_seq_ctrl #(.AW(AW), .DW(DW), .BUF_WORDS(BUFW), .POLL_LIMIT(LIMIT)) u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_program(op_program), .op_addr(op_addr), .op_count(op_count),
        .wr_data(wr_data), .data_take(data_take), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .done(done), .status(status)
    );

    // ---------------- expected-cycle builders ----------------
    task automatic push(int kind, int addr, int wd, int rd, int take, int st);
        ent_t e;
        e.kind = kind; e.addr = addr; e.wdata = wd; e.rdata = rd;
        e.take = take; e.st = st; e.req = cur;
        q.push_back(e);
    endtask

    task automatic wr(int a, int d);        push(K_WR, a, d, 0, 0, 0); endtask
    task automatic rd(int a, int v);        push(K_RD, a, 0, v, 0, 0); endtask
    task automatic fin(int st);             push(K_DONE, 0, 0, 0, 0, st); endtask
    task automatic unlock();                wr('h555, 'hAA); wr('h2AA, 'h55); endtask
    task automatic abort_seq();             unlock(); wr('h555, 'hF0); endtask

    task automatic busy_poll(int a, int v);
        rd(a, v); rd(a, v ^ 'h40); rd(a, v);
    endtask

    task automatic idle_poll(int a);
        rd(a, 'h80); rd(a, 'h80); rd(a, 'h80);
    endtask

    function automatic int dval(int a, int i);
        return (a * 3 + i * 'h0101 + 'h5A00) & 'hFFFF;
    endfunction

    task automatic erase_head(int a);
        push(K_IDLE, 0, 0, 0, 0, 0);
        unlock(); wr('h555, 'h80); unlock(); wr(a, 'h30);
    endtask

    task automatic prog_head(int a, int n);
        push(K_IDLE, 0, 0, 0, 0, 0);
        unlock(); wr(a, 'h25); wr(a, n - 1);
        for (int i = 0; i < n; i++) push(K_WR, a + i, dval(a, i), 0, 1, 0);
        wr(a, 'h29);
    endtask

    // ---------------- request driver ----------------
    task automatic issue(bit prog, int a, int n, int hold);
        op_program = prog; op_addr = AW'(a); op_count = CW'(n); op_valid = 1'b1;
        @(posedge clk); #2;
        for (int k = 0; k < hold; k++) begin
            op_program = ~prog; op_count = CW'(1);
            @(posedge clk); #2;
        end
        op_valid = 1'b0;
        while (q.size() != 0) @(posedge clk);
        #2;
    endtask

    // ---------------- flash responder and per-cycle compare ----------------
    initial begin
        forever begin
            @(posedge clk); #1;
            if (q.size() != 0) begin
                bus_rdata = DW'(q[0].rdata);
                wr_data   = DW'(q[0].wdata);
            end else begin
                bus_rdata = '0;
                wr_data   = '0;
            end
            @(negedge clk);
            if (armed) begin
                ent_t e;
                logic [46:0] act, exp_v;
                if (q.size() != 0) e = q.pop_front();
                else begin
                    e.kind = K_IDLE; e.addr = 0; e.wdata = 0; e.rdata = 0;
                    e.take = 0; e.st = 0; e.req = "R10";
                end
                act = {op_ready, bus_en, bus_we, data_take, done, status, bus_addr, bus_wdata};
                case (e.kind)
                    K_BOOT:  exp_v = {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, AW'(0), DW'(0)};
                    K_IDLE:  exp_v = {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, AW'(0), DW'(0)};
                    K_WR:    exp_v = {1'b0, 1'b1, 1'b1, e.take[0], 1'b0, 2'd0, AW'(e.addr), DW'(e.wdata)};
                    K_RD:    exp_v = {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, AW'(e.addr), DW'(0)};
                    default: exp_v = {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'(e.st), AW'(0), DW'(0)};
                endcase
                if (e.kind != K_DONE) act[41:40] = 2'd0;
                if (e.kind != K_WR && e.kind != K_RD) act[39:0] = '0;
                if (e.kind == K_RD) act[15:0] = '0;
                n_vec++;
                if (act !== exp_v) begin
                    n_bad++;
                    $display("FAIL %s cycle-compare actual=%h expected=%h (rdy,en,we,take,done,st,addr,wdata)",
                             e.req, act, exp_v);
                end
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(150000 * 10);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    // ---------------- scenarios ----------------
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        n_vec++;
        if (bus_en !== 1'b0 || done !== 1'b0 || op_ready !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset actual=%b%b%b expected=000", bus_en, done, op_ready);
        end
        @(posedge clk); #2;
        cur = "R1";
        push(K_BOOT, 0, 0, 0, 0, 0);
        abort_seq();
        armed = 1'b1;
        rst_n = 1'b1;
        while (q.size() != 0) @(posedge clk);
        #2;

        // R2/R3/R4: erase, two reads without ack, one busy poll, then idle
        cur = "R2";  erase_head('h1234);
        cur = "R3";  rd('h1234, 'h00); rd('h1234, 'h00); rd('h1234, 'h08);
        cur = "R4";  busy_poll('h1234, 'h00); idle_poll('h1234); fin(0);
        issue(1'b0, 'h1234, 1, 0);

        // R6/R4: erase ignores bit 1; a single toggling pair is not busy
        cur = "R6";  erase_head('h0800); rd('h0800, 'h08); busy_poll('h0800, 'h02);
        cur = "R4";  rd('h0800, 'h00); rd('h0800, 'h40); rd('h0800, 'h40); fin(0);
        issue(1'b0, 'h0800, 3, 0);

        // R5: erase device error with bit 5 while busy
        cur = "R5";  erase_head('h2000); rd('h2000, 'h08); busy_poll('h2000, 'h20);
        abort_seq(); fin(1);
        issue(1'b0, 'h2000, 1, 0);

        // R7/R6: program 4 words, bit 1 fails a program; R10 held request
        cur = "R7";  prog_head('h0100, 4);
        cur = "R6";  busy_poll('h0100, 'h02); abort_seq(); fin(1);
        cur = "R10";
        issue(1'b1, 'h0100, 4, 3);

        // R7: single word program succeeds
        cur = "R7";  prog_head('h0333, 1); idle_poll('h0333); fin(0);
        issue(1'b1, 'h0333, 1, 0);

        // R8: full buffer accepted, then oversize and zero rejected
        cur = "R8";  prog_head('h4000, BUFW); busy_poll('h4000, 'h00); idle_poll('h4000); fin(0);
        issue(1'b1, 'h4000, BUFW, 0);
        cur = "R8";  push(K_IDLE, 0, 0, 0, 0, 0); fin(3);
        issue(1'b1, 'h4000, BUFW + 1, 0);
        cur = "R8";  push(K_IDLE, 0, 0, 0, 0, 0); fin(3);
        issue(1'b1, 'h4000, 0, 0);

        // R9: toggle poll never settles
        cur = "R9";  erase_head('h3000); rd('h3000, 'h08);
        for (int i = 0; i < LIMIT; i++) busy_poll('h3000, 'h00);
        abort_seq(); fin(2);
        issue(1'b0, 'h3000, 1, 0);

        // R9: erase ack bit never appears
        cur = "R9";  erase_head('h3100);
        for (int i = 0; i < LIMIT; i++) rd('h3100, 'h00);
        abort_seq(); fin(2);
        issue(1'b0, 'h3100, 1, 0);

        // R9/R4: timeout recovery leaves the block usable
        cur = "R4";  erase_head('h0010); rd('h0010, 'h08); idle_poll('h0010); fin(0);
        issue(1'b0, 'h0010, 1, 0);

        repeat (3) @(posedge clk);
        summary();
    end

endmodule